// File: doc/BRIEF.md
# Gated retriggerable one-shot pulse generator

This block is a clocked replacement for a dual retriggerable monostable. Each channel watches two trigger lines of opposite sense: a falling edge on line A fires the channel when line B is high, and a rising edge on line B fires it when line A is low. A fired channel drives Q high and Qn low for a programmed number of clock cycles. A new valid trigger during a pulse reloads the full count, so a steady stream of triggers keeps Q high for as long as needed.

A per-channel active-low clear ends a running pulse at once and blocks triggering while it is held low. The number of channels and the width of the pulse-length input are parameters, and each channel has its own inputs, length and outputs. All inputs are expected to be synchronous to the clock already. A synchronous active-low reset returns every channel to idle.

Top module: `retrig_oneshot`

## Requirements
- R1: In a cycle where A is low, A was high in the previous cycle, B is high and clear is high, the channel triggers, and Q is high from the next cycle on. A falling A edge while B is low starts no pulse.
- R2: In a cycle where B is high, B was low in the previous cycle, A is low and clear is high, the channel triggers. A rising B edge while A is high starts no pulse.
- R3: After a trigger with a nonzero length W (the channel's slice of `width`, sampled in the trigger cycle), Q stays high for exactly W cycles and then returns low.
- R4: A valid trigger during a pulse reloads the count, so Q stays high for W cycles after that latest trigger.
- R5: While a pulse runs, Q is 1 and Qn is 0; while idle, Q is 0 and Qn is 1.
- R6: Driving clear low forces Q low in that same cycle and ends the pulse; it does not resume when clear returns high.
- R7: Edges on A or B in a cycle where clear is low start no pulse.
- R8: A low-to-high change of clear, with A and B unchanged, starts no pulse even when A is low and B is high.
- R9: A trigger in the last cycle of a pulse reloads the count with no idle cycle on Q.
- R10: A trigger while the length is 0 starts no pulse and leaves a running pulse counting down unchanged.
- R11: Channels are independent: a trigger, clear or length on one channel has no effect on another channel's outputs.
- R12: While `rstN` is low at a clock edge, all channels go idle (Q low, Qn high) after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Synchronous active-low reset |
| trigA | input | NumChan | Falling-edge trigger line A, one bit per channel |
| trigB | input | NumChan | Rising-edge trigger line B, one bit per channel |
| clearN | input | NumChan | Active-low clear, one bit per channel |
| width | input | NumChan*WidthBits | Pulse length in cycles, channel i in bits [i*WidthBits +: WidthBits] |
| q | output | NumChan | Pulse output, high while active |
| qn | output | NumChan | Complement of q |

## Verification
The bench builds the block with its defaults, two channels and a 16-bit length, and programs short lengths of 0, 2, 3, 4, 5 and 8 cycles, so that every pulse ends within a few cycles. These short lengths make it possible to retrigger in the last cycle of a pulse, to land a zero-length trigger inside a running pulse, and to clear and release a channel while the other one runs, all within a short run. The full 16-bit range is only carried through the reload path.

// File: rtl/oneshot_pkg.sv
package oneshot_pkg;

  // Strobes from a channel's control to its counter
  typedef struct packed {
    logic load;   // reload the counter with the programmed length
    logic clear;  // force the counter to zero
    logic step;   // count one cycle down
  } pulseCtl_t;

endpackage

// File: rtl/oneshot_ctrl.sv
module oneshot_ctrl
  import oneshot_pkg::*;
(
  input  logic      clk,
  input  logic      trigA,
  input  logic      trigB,
  input  logic      clearN,
  input  logic      widthZero,
  input  logic      active,
  output pulseCtl_t ctl
);

  logic aPrev;
  logic bPrev;
  logic fallA;
  logic riseB;
  logic armed;

  // One-cycle history of the trigger lines. It follows the inputs in reset
  // too, so leaving reset never sees a stale edge.
  always_ff @(posedge clk) begin
    aPrev <= trigA;
    bPrev <= trigB;
  end

  assign fallA = aPrev & ~trigA;
  assign riseB = ~bPrev & trigB;

  // Each edge is qualified by the level of the other line
  assign armed = (fallA & trigB) | (riseB & ~trigA);

  always_comb begin
    ctl.clear = ~clearN;
    ctl.load  = clearN & armed & ~widthZero;
    ctl.step  = clearN & ~ctl.load & active;
  end

endmodule

// File: rtl/oneshot_count.sv
module oneshot_count
  import oneshot_pkg::*;
#(
  parameter int WidthBits = 16
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  pulseCtl_t            ctl,
  input  logic [WidthBits-1:0] widthIn,
  output logic                 active
);

  localparam logic [WidthBits-1:0] One = WidthBits'(1);

  logic [WidthBits-1:0] cnt;

  always_ff @(posedge clk) begin
    if (!rstN || ctl.clear) begin
      cnt <= '0;
    end else if (ctl.load) begin
      cnt <= widthIn;
    end else if (ctl.step) begin
      cnt <= cnt - One;
    end
  end

  assign active = (cnt != '0);

  // R4 / R9: a load strobe leaves the full programmed length in the counter
  a_r4_reload_full: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.load && !ctl.clear) |=> (cnt == $past(widthIn)));

  // R3: a step strobe removes exactly one cycle
  a_r3_step_one: assert property (@(posedge clk) disable iff (!rstN)
    (ctl.step && !ctl.clear && !ctl.load) |=> (cnt == $past(cnt) - One));

endmodule

// File: rtl/retrig_oneshot.sv
module retrig_oneshot
  import oneshot_pkg::*;
#(
  parameter int NumChan   = 2,
  parameter int WidthBits = 16
) (
  input  logic                           clk,
  input  logic                           rstN,
  input  logic [NumChan-1:0]             trigA,
  input  logic [NumChan-1:0]             trigB,
  input  logic [NumChan-1:0]             clearN,
  input  logic [NumChan*WidthBits-1:0]   width,
  output logic [NumChan-1:0]             q,
  output logic [NumChan-1:0]             qn
);

  logic [NumChan-1:0] active;

  for (genvar i = 0; i < NumChan; i++) begin : g_chan
    pulseCtl_t            ctl;
    logic [WidthBits-1:0] chWidth;

    assign chWidth = width[i*WidthBits +: WidthBits];

    oneshot_ctrl u_ctrl (
      .clk       (clk),
      .trigA     (trigA[i]),
      .trigB     (trigB[i]),
      .clearN    (clearN[i]),
      .widthZero (chWidth == '0),
      .active    (active[i]),
      .ctl       (ctl)
    );

    oneshot_count #(.WidthBits(WidthBits)) u_count (
      .clk     (clk),
      .rstN    (rstN),
      .ctl     (ctl),
      .widthIn (chWidth),
      .active  (active[i])
    );

    // Clear gates the output without waiting for the counter
    assign q[i]  = active[i] & clearN[i];
    assign qn[i] = ~q[i];

    // R1: qualified falling edge on A starts a pulse
    a_r1_fall_a_fires: assert property (@(posedge clk) disable iff (!rstN)
      (clearN[i] && $past(trigA[i]) && !trigA[i] && trigB[i] && chWidth != '0)
      |=> active[i]);

    // R2: qualified rising edge on B starts a pulse
    a_r2_rise_b_fires: assert property (@(posedge clk) disable iff (!rstN)
      (clearN[i] && !$past(trigB[i]) && trigB[i] && !trigA[i] && chWidth != '0)
      |=> active[i]);

    // R6: a low clear empties the counter at the next edge
    a_r6_clear_ends: assert property (@(posedge clk) disable iff (!rstN)
      !clearN[i] |=> !active[i]);

    // R8: releasing clear with steady trigger lines starts nothing
    a_r8_release_quiet: assert property (@(posedge clk) disable iff (!rstN)
      ($rose(clearN[i]) && $stable(trigA[i]) && $stable(trigB[i]) && !active[i])
      |=> !active[i]);
  end

endmodule

// File: tb/retrig_oneshot_tb_top.sv
`timescale 1ns/100ps
module retrig_oneshot_tb_top;

  localparam int NumChan   = 2;
  localparam int WidthBits = 16;

  logic                         clk = 1'b0;
  logic                         rstN;
  logic [NumChan-1:0]           a;
  logic [NumChan-1:0]           b;
  logic [NumChan-1:0]           c;
  logic [WidthBits-1:0]         w [NumChan];
  logic [NumChan*WidthBits-1:0] widthFlat;
  logic [NumChan-1:0]           q;
  logic [NumChan-1:0]           qn;

  int vectors = 0;
  int misses  = 0;

  always #2.5 clk = ~clk;

  always_comb begin
    for (int i = 0; i < NumChan; i++) widthFlat[i*WidthBits +: WidthBits] = w[i];
  end

  retrig_oneshot #(.NumChan(NumChan), .WidthBits(WidthBits)) dut_i (
    .clk(clk), .rstN(rstN), .trigA(a), .trigB(b), .clearN(c),
    .width(widthFlat), .q(q), .qn(qn)
  );

  // Behavioural reference: remaining cycles per channel
  int mCnt [NumChan];
  bit mPa  [NumChan];
  bit mPb  [NumChan];

  always @(posedge clk) begin
    for (int i = 0; i < NumChan; i++) begin
      bit fire;
      fire = c[i] && ((mPa[i] && !a[i] && b[i]) || (!mPb[i] && b[i] && !a[i]));
      if (!rstN || !c[i]) mCnt[i] = 0;
      else if (fire && w[i] != 0) mCnt[i] = int'(w[i]);
      else if (mCnt[i] > 0) mCnt[i] = mCnt[i] - 1;
      mPa[i] = a[i];
      mPb[i] = b[i];
    end
  end

  task automatic compare(input string tag);
    logic [NumChan-1:0] expQ;
    for (int i = 0; i < NumChan; i++) expQ[i] = (mCnt[i] != 0) && c[i];
    vectors++;
    if (q !== expQ || qn !== ~expQ) begin
      misses++;
      $display("FAIL %s: q=%b qn=%b expected q=%b qn=%b", tag, q, qn, expQ, ~expQ);
    end
  endtask

  task automatic drive(input logic [1:0] na, input logic [1:0] nb,
                       input logic [1:0] nc, input int n, input string tag);
    repeat (n) begin
      @(negedge clk);
      a = na; b = nb; c = nc;
      #1 compare(tag);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  endtask

  initial begin
    #(200000 * 5);
    misses++;
    $display("FAIL watchdog: run did not end, expected completion");
    finish_run();
  end

  initial begin
    rstN = 1'b0; a = 2'b11; b = 2'b00; c = 2'b11;
    w[0] = 16'd4; w[1] = 16'd2;
    repeat (3) @(negedge clk);
    drive(2'b11, 2'b00, 2'b11, 2, "R12 reset idle");
    @(negedge clk); rstN = 1'b1;
    drive(2'b11, 2'b00, 2'b11, 2, "R5 idle levels");

    // B rises while A high: no trigger; then A falls with B high
    drive(2'b11, 2'b01, 2'b11, 2, "R2 rise B blocked by A high");
    drive(2'b10, 2'b01, 2'b11, 7, "R1 R3 fall A pulse of 4");

    // A low, B rises
    drive(2'b10, 2'b00, 2'b11, 1, "R2 setup");
    drive(2'b10, 2'b01, 2'b11, 7, "R2 R5 rise B pulse");

    // A falls while B low
    drive(2'b11, 2'b00, 2'b11, 2, "R1 setup");
    drive(2'b10, 2'b00, 2'b11, 3, "R1 fall A blocked by B low");

    // Retrigger mid-pulse
    drive(2'b11, 2'b01, 2'b11, 1, "R4 setup");
    drive(2'b10, 2'b01, 2'b11, 2, "R4 first trigger");
    drive(2'b11, 2'b01, 2'b11, 1, "R4 running");
    drive(2'b10, 2'b01, 2'b11, 7, "R4 retrigger extends");

    // Retrigger on last cycle with length 2
    w[0] = 16'd2;
    drive(2'b11, 2'b01, 2'b11, 1, "R9 setup");
    drive(2'b10, 2'b01, 2'b11, 1, "R9 trigger");
    drive(2'b11, 2'b01, 2'b11, 1, "R9 count 2");
    drive(2'b10, 2'b01, 2'b11, 4, "R9 tie no gap");

    // Clear cuts a long pulse
    w[0] = 16'd8;
    drive(2'b11, 2'b01, 2'b11, 1, "R6 setup");
    drive(2'b10, 2'b01, 2'b11, 3, "R6 pulse running");
    drive(2'b10, 2'b01, 2'b10, 2, "R6 clear low");
    drive(2'b11, 2'b01, 2'b10, 1, "R7 A rises in clear");
    drive(2'b10, 2'b01, 2'b10, 1, "R7 A falls in clear");
    drive(2'b10, 2'b00, 2'b10, 1, "R7 B low in clear");
    drive(2'b10, 2'b01, 2'b10, 2, "R7 B rises in clear");
    drive(2'b10, 2'b01, 2'b11, 4, "R8 release quiet");
    drive(2'b10, 2'b01, 2'b11, 2, "R6 no resume");

    // Zero length
    w[0] = 16'd0;
    drive(2'b11, 2'b01, 2'b11, 1, "R10 setup");
    drive(2'b10, 2'b01, 2'b11, 3, "R10 zero length no pulse");
    w[0] = 16'd5;
    drive(2'b11, 2'b01, 2'b11, 1, "R10 setup 2");
    drive(2'b10, 2'b01, 2'b11, 2, "R10 pulse of 5");
    w[0] = 16'd0;
    drive(2'b11, 2'b01, 2'b11, 1, "R10 running");
    drive(2'b10, 2'b01, 2'b11, 5, "R10 zero trigger keeps count");

    // Independent channels
    w[0] = 16'd4; w[1] = 16'd3;
    drive(2'b01, 2'b01, 2'b11, 1, "R11 setup");
    drive(2'b01, 2'b11, 2'b11, 2, "R11 ch1 rise B");
    drive(2'b00, 2'b11, 2'b11, 2, "R11 ch0 fall A");
    drive(2'b00, 2'b11, 2'b01, 2, "R11 clear ch1 only");
    drive(2'b00, 2'b11, 2'b11, 4, "R11 ch0 continues");

    // Reset during a pulse
    drive(2'b01, 2'b11, 2'b11, 1, "R12 setup");
    drive(2'b00, 2'b11, 2'b11, 2, "R12 pulse running");
    @(negedge clk); rstN = 1'b0;
    drive(2'b00, 2'b11, 2'b11, 2, "R12 reset mid pulse");
    @(negedge clk); rstN = 1'b1;
    drive(2'b00, 2'b11, 2'b11, 3, "R12 idle after reset");

    finish_run();
  end

endmodule